// File: doc/BRIEF.md
# Four-Channel Timer Bank

This block holds four 16-bit general-purpose timers behind a flat register bus. Each timer has its own address window and carries a count, a mode word, a compare value and, on the first two timers only, a hold word. One shared `tick_en` input is the prescaled time base: on every cycle with `tick_en` high, each timer whose count-up bit is set advances by one. A timer fires when its count reaches the compare value with compare interrupts enabled, or when it wraps from 0xFFFF to 0 with overflow interrupts enabled.

A firing timer raises its bit of `irq` for one clock. If its zero-return bit is set, its count goes back to zero. Timer 0 is periodic and keeps its mode word after firing. Timers 1 to 3 are single-shot: firing clears their compare-enable and overflow-flag bits. Reads return data combinationally in the cycle `bus_rd` is high, and writes take effect at the clock edge. Any access to a hold register that does not exist raises `bad_acc`.

The design has no sequencer. A decoder turns the address into a timer index and a register kind, one channel module per timer does the counting and event logic, and the top module routes write strobes and muxes read data.

Top module: `tmr_bank`

## Requirements
- R1: Address bits [12:11] select the timer. Inside a window, offset 0x00 is count, 0x10 is mode, 0x20 is compare and 0x30 is hold. An access to one timer never changes another timer.
- R2: A write to count loads bits [15:0] of the write data into the counter. If a tick arrives in the same cycle, the write wins. Read data is the 16-bit value zero-extended to 32 bits.
- R3: On a cycle with `tick_en` high, a timer whose count-up bit (mode bit 7) is set adds one to its count. With `tick_en` low, or with bit 7 clear, the count does not change.
- R4: With compare enable (mode bit 8) set, a counting timer fires on the tick that brings its count equal to compare. Its `irq` bit is high for exactly the one cycle after that tick edge.
- R5: A counting timer at 0xFFFF wraps to 0 on the next tick and sets the overflow flag (mode bit 11). If overflow enable (mode bit 9) is set, the wrap also fires the timer.
- R6: When a timer fires with zero-return (mode bit 6) set, its count becomes 0 instead of the incremented value.
- R7: After firing, timers 1, 2 and 3 clear mode bits 8 and 11 and do not fire on a later compare match. Timer 0 keeps its mode word and fires again every time the count reaches compare.
- R8: Hold registers on timers 0 and 1 can be written and read back. On timers 2 and 3, a hold read returns 0, a hold write is dropped, and `bad_acc` is high during the access.
- R9: Offsets other than the four listed read as 0, and writes to them change nothing.
- R10: After reset, all registers read 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Shared prescaled count tick |
| bus_addr | input | 13 | Register address (bits [12:11] select the timer) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| bad_acc | output | 1 | High while a missing hold register is accessed |
| irq | output | 4 | One-cycle event pulse per timer |

## Verification
The overflow path is the hardest to reach from the ports, because a free-running count needs 65536 ticks to wrap. The bench uses the count write to preload 0xFFFE or 0xFFFF, so a wrap happens within one or two ticks. That makes both the single-shot clearing of the flag and the flag being kept on timer 0 observable. A second hard case is a count write landing in the same cycle as a tick. The bench holds `tick_en` high across the write cycle and then reads the count back.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    // mode word bit positions
    localparam int MB_ZRET = 6;
    localparam int MB_CUE  = 7;
    localparam int MB_CMPE = 8;
    localparam int MB_OVFE = 9;
    localparam int MB_OVFF = 11;

    typedef enum logic [2:0] {
        SEL_COUNT,
        SEL_MODE,
        SEL_COMP,
        SEL_HOLD,
        SEL_NONE
    } reg_sel_e;
endpackage

// File: rtl/tmr_decode.sv
`timescale 1ns/1ps
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int WIN_LSB = 11,
    parameter int IDX_W   = 2,
    localparam int ADDR_W = WIN_LSB + IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output reg_sel_e          sel
);
    localparam logic [WIN_LSB-1:0] OFS_COUNT = WIN_LSB'(8'h00);
    localparam logic [WIN_LSB-1:0] OFS_MODE  = WIN_LSB'(8'h10);
    localparam logic [WIN_LSB-1:0] OFS_COMP  = WIN_LSB'(8'h20);
    localparam logic [WIN_LSB-1:0] OFS_HOLD  = WIN_LSB'(8'h30);

    logic [WIN_LSB-1:0] ofs;

    assign idx = addr[ADDR_W-1:WIN_LSB];
    assign ofs = addr[WIN_LSB-1:0];

    always_comb begin
        if (ofs == OFS_COUNT)     sel = SEL_COUNT;
        else if (ofs == OFS_MODE) sel = SEL_MODE;
        else if (ofs == OFS_COMP) sel = SEL_COMP;
        else if (ofs == OFS_HOLD) sel = SEL_HOLD;
        else                      sel = SEL_NONE;
    end
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter bit HAS_HOLD = 1'b1,
    parameter bit ONE_SHOT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_cnt,
    input  logic             wr_mode,
    input  logic             wr_comp,
    input  logic             wr_hold,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] mode_q,
    output logic [CNT_W-1:0] comp_q,
    output logic [CNT_W-1:0] hold_q,
    output logic             irq_q
);
    logic             counting;
    logic [CNT_W-1:0] cnt_inc;
    logic             ovf;
    logic             hit;
    logic             fire;

    assign counting = mode_q[MB_CUE];
    assign cnt_inc  = cnt_q + CNT_W'(1);
    assign ovf      = tick_en && counting && (cnt_q == '1);
    assign hit      = tick_en && counting && mode_q[MB_CMPE] && (cnt_inc == comp_q);
    assign fire     = hit || (ovf && mode_q[MB_OVFE]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= wdata;
        end else if (tick_en && counting) begin
            cnt_q <= (fire && mode_q[MB_ZRET]) ? '0 : cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_mode) begin
            mode_q <= wdata;
        end else begin
            if (ovf) mode_q[MB_OVFF] <= 1'b1;
            if (fire && ONE_SHOT) begin
                mode_q[MB_CMPE] <= 1'b0;
                mode_q[MB_OVFF] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            comp_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_comp) comp_q <= wdata;
            irq_q <= fire;
        end
    end

    generate
        if (HAS_HOLD) begin : g_hold
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       hold_q <= '0;
                else if (wr_hold) hold_q <= wdata;
            end
        end else begin : g_nohold
            logic unused_hold;
            assign unused_hold = wr_hold;
            assign hold_q = '0;
        end
    endgenerate

    // R3: no tick and no load -> count frozen
    p_count_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_cnt) |=> $stable(cnt_q));

    // R4: an event pulse always follows a tick cycle
    p_irq_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(tick_en));

    // R6: zero-return leaves the count at zero after an event
    p_zret_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && $past(mode_q[MB_ZRET]) && !$past(wr_cnt)) |-> (cnt_q == '0));

    generate
        if (ONE_SHOT) begin : g_oneshot_chk
            // R7: single-shot timers are disarmed after firing
            p_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_q && !$past(wr_mode)) |-> (!mode_q[MB_CMPE] && !mode_q[MB_OVFF]));
        end
    endgenerate
endmodule

// File: rtl/tmr_bank.sv
`timescale 1ns/1ps
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int N_TIMERS = 4,
    parameter int N_HOLD   = 2,
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 32,
    parameter int WIN_LSB  = 11,
    localparam int IDX_W   = $clog2(N_TIMERS),
    localparam int ADDR_W  = WIN_LSB + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bad_acc,
    output logic [N_TIMERS-1:0] irq
);
    logic [IDX_W-1:0] idx;
    reg_sel_e         sel;
    logic [CNT_W-1:0] cnt_a  [N_TIMERS];
    logic [CNT_W-1:0] mode_a [N_TIMERS];
    logic [CNT_W-1:0] comp_a [N_TIMERS];
    logic [CNT_W-1:0] hold_a [N_TIMERS];
    logic [CNT_W-1:0] rsel;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

    tmr_decode #(.WIN_LSB(WIN_LSB), .IDX_W(IDX_W)) u_dec (
        .addr (bus_addr),
        .idx  (idx),
        .sel  (sel)
    );

    generate
        for (genvar i = 0; i < N_TIMERS; i++) begin : g_ch
            logic hit_me;
            assign hit_me = bus_wr && (32'(idx) == i);

            tmr_channel #(
                .CNT_W    (CNT_W),
                .HAS_HOLD (i < N_HOLD),
                .ONE_SHOT (i != 0)
            ) u_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick_en (tick_en),
                .wr_cnt  (hit_me && sel == SEL_COUNT),
                .wr_mode (hit_me && sel == SEL_MODE),
                .wr_comp (hit_me && sel == SEL_COMP),
                .wr_hold (hit_me && sel == SEL_HOLD),
                .wdata   (bus_wdata[CNT_W-1:0]),
                .cnt_q   (cnt_a[i]),
                .mode_q  (mode_a[i]),
                .comp_q  (comp_a[i]),
                .hold_q  (hold_a[i]),
                .irq_q   (irq[i])
            );
        end
    endgenerate

    always_comb begin
        unique case (sel)
            SEL_COUNT: rsel = cnt_a[idx];
            SEL_MODE:  rsel = mode_a[idx];
            SEL_COMP:  rsel = comp_a[idx];
            SEL_HOLD:  rsel = hold_a[idx];
            default:   rsel = '0;
        endcase
    end

    assign bus_rdata = DATA_W'(rsel);
    assign bad_acc   = (bus_rd || bus_wr) && (sel == SEL_HOLD) && (32'(idx) >= N_HOLD);

    // R8: a flagged hold access never returns data
    p_bad_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_acc && bus_rd) |-> (bus_rdata == '0));

    // R10: no event pulse right after reset release
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq == '0));
endmodule

// File: tb/tb_tmr_bank.sv
`timescale 1ns/1ps
module tb_tmr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [12:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bad_acc;
    logic [3:0]  irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    int          irq_cnt [4] = '{0, 0, 0, 0};

    always #2.5 clk = ~clk;

    tmr_bank dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bad_acc(bad_acc), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as the design returns it
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 4; i++) irq_cnt[i] += int'(irq[i]);
            if (bus_rd) begin
                if (exp_q.size() == 0) check("read with no expectation", 32'd1, 32'd0);
                else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    function automatic logic [12:0] ra(input int t, input int ofs);
        return 13'(t * 32'h800 + ofs);
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        step();
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) step();
        tick_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int base;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();

        // R10: reset state
        check("R10 irq after reset", 32'(irq), 32'd0);
        rd(ra(0, 'h00), 0, "R10 count0 reset");
        rd(ra(3, 'h10), 0, "R10 mode3 reset");
        rd(ra(1, 'h20), 0, "R10 comp1 reset");

        // R2: direct load, upper bits dropped
        wr(ra(1, 'h00), 32'hABCD_1234);
        rd(ra(1, 'h00), 32'h1234, "R2 count1 load");
        // R3: ticks with count-up disabled leave the count alone
        ticks(3);
        rd(ra(1, 'h00), 32'h1234, "R3 count1 no CUE");

        // R3: counting on timer 2
        wr(ra(2, 'h10), 32'h80);
        ticks(5);
        rd(ra(2, 'h00), 5, "R3 count2 after 5 ticks");
        repeat (4) step();
        rd(ra(2, 'h00), 5, "R3 count2 without tick");
        // R1: other windows untouched
        rd(ra(1, 'h00), 32'h1234, "R1 count1 isolated");
        rd(ra(3, 'h00), 0, "R1 count3 isolated");

        // R2: write wins over a tick in the same cycle
        tick_en = 1'b1;
        wr(ra(2, 'h00), 32'h40);
        tick_en = 1'b0;
        rd(ra(2, 'h00), 32'h40, "R2 write beats tick");
        wr(ra(2, 'h10), 0);

        // R7/R6/R4: timer 0 periodic with zero-return, compare 3
        wr(ra(0, 'h20), 3);
        wr(ra(0, 'h00), 0);
        wr(ra(0, 'h10), 32'h1C0);
        base = irq_cnt[0];
        ticks(9);
        rd(ra(0, 'h00), 0, "R6 count0 zeroed");
        check("R7 timer0 fired three times", 32'(irq_cnt[0] - base), 32'd3);
        rd(ra(0, 'h10), 32'h1C0, "R7 mode0 kept");
        wr(ra(0, 'h10), 0);

        // R4/R7: timer 1 single-shot, compare 2
        wr(ra(1, 'h20), 2);
        wr(ra(1, 'h00), 0);
        wr(ra(1, 'h10), 32'h180);
        ticks(1);
        check("R4 irq1 before match", 32'(irq[1]), 32'd0);
        ticks(1);
        check("R4 irq1 on match", 32'(irq[1]), 32'd1);
        step();
        check("R4 irq1 one cycle", 32'(irq[1]), 32'd0);
        rd(ra(1, 'h10), 32'h080, "R7 mode1 disarmed");
        rd(ra(1, 'h00), 2, "R4 count1 no zero-return");
        base = irq_cnt[1];
        wr(ra(1, 'h00), 0);
        ticks(4);
        step();
        check("R7 timer1 no refire", 32'(irq_cnt[1] - base), 32'd0);
        wr(ra(1, 'h10), 0);

        // R5: overflow on timer 3
        wr(ra(3, 'h00), 32'hFFFE);
        wr(ra(3, 'h10), 32'h280);
        ticks(1);
        check("R5 irq3 before wrap", 32'(irq[3]), 32'd0);
        ticks(1);
        check("R5 irq3 on wrap", 32'(irq[3]), 32'd1);
        rd(ra(3, 'h00), 0, "R5 count3 wrapped");
        rd(ra(3, 'h10), 32'h280, "R7 OVFF cleared on timer3");
        wr(ra(3, 'h10), 0);
        // R5: flag kept on timer 0, no event without enable
        wr(ra(0, 'h00), 32'hFFFF);
        wr(ra(0, 'h10), 32'h80);
        ticks(1);
        check("R5 irq0 without OVFE", 32'(irq[0]), 32'd0);
        rd(ra(0, 'h10), 32'h880, "R5 OVFF set timer0");
        rd(ra(0, 'h00), 0, "R5 count0 wrapped");
        wr(ra(0, 'h10), 0);

        // R8: hold registers
        wr(ra(0, 'h30), 32'hBEEF);
        wr(ra(1, 'h30), 32'h1111);
        rd(ra(0, 'h30), 32'hBEEF, "R8 hold0");
        rd(ra(1, 'h30), 32'h1111, "R8 hold1");
        bus_addr = ra(2, 'h30); bus_wdata = 32'h5555; bus_wr = 1'b1;
        #1 check("R8 bad_acc on hold2 write", 32'(bad_acc), 32'd1);
        step();
        bus_wr = 1'b0;
        bus_addr = ra(3, 'h30); bus_rd = 1'b1;
        #1 check("R8 bad_acc on hold3 read", 32'(bad_acc), 32'd1);
        bus_rd = 1'b0;
        rd(ra(2, 'h30), 0, "R8 hold2 reads zero");
        bus_addr = ra(1, 'h30); bus_rd = 1'b1;
        #1 check("R8 no bad_acc on hold1", 32'(bad_acc), 32'd0);
        bus_rd = 1'b0;

        // R9: reserved offsets
        wr(ra(0, 'h00), 32'h77);
        wr(ra(0, 'h08), 32'h99);
        rd(ra(0, 'h08), 0, "R9 reserved reads zero");
        rd(ra(0, 'h40), 0, "R9 offset 0x40 zero");
        rd(ra(0, 'h00), 32'h77, "R9 reserved write ignored");

        step();
        finish_run();
    end
endmodule